// File: doc/BRIEF.md
# Shared Address Bus Arbiter with Starvation Lock

This block chooses, once per bus cycle, which of 36 masters may drive a shared address bus. Twenty of the masters are processors and sixteen are memory-bank controllers. Each master raises a request line and holds it until it sees its grant bit. Under normal load the arbiter serves masters in a circular order that starts just after the last winner, so every master gets a fair turn.

Each master also has a wait counter in the arbiter. When a master has waited as long as the runtime limit allows, it is marked as starving. While any master is starving, the arbiter grants the bus only to starving masters and shuts out every other master. Several starving masters are served in the same circular order. A limit of zero turns the starvation lock off.

The data bus is arbitrated elsewhere. All pins are plain control pins. There is no valid/ready stream, so there is no back-pressure: a request that is not granted simply stays up and is considered again in the next cycle.

Top module: `bus_addr_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant` is all zero and `grant_valid` is low. After reset the circular pointer starts at index 0.
- R2: `grant` has at most one bit set in every cycle, and `grant_valid` is high exactly when one bit is set.
- R3: The requests and the limit are sampled at a clock edge, and the resulting grant appears right after that edge. A grant lasts one cycle and is decided again at the next edge.
- R4: The winner is the first requesting index at or above the pointer, wrapping from 35 to 0. After a grant the pointer moves to the winner's index plus one, modulo 36.
- R5: Processor line p maps to index p (0 to 19). Memory-bank line m maps to index 20+m (20 to 35). Grant bit k belongs to index k.
- R6: A master's wait count rises by one in each cycle in which it requests and is not granted. The count stops rising at the limit. It returns to zero when the master is granted or drops its request.
- R7: With a nonzero limit, a requesting master whose count has reached the limit is starving. While any master is starving, only starving masters can be granted, even if the circular order would pick another master.
- R8: Two or more starving masters are resolved among themselves by the same circular pointer.
- R9: A limit of zero disables starvation, so the grant follows the circular order alone.
- R10: In a cycle with no requests, no grant is given and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_proc | input | 20 | Request lines of the processor masters (indices 0 to 19) |
| req_mem | input | 16 | Request lines of the memory-bank masters (indices 20 to 35) |
| wait_limit | input | 8 | Cycles a master may wait before it starves; 0 disables the lock |
| grant | output | 36 | One-hot grant, registered |
| grant_valid | output | 1 | High when some grant bit is set |

## Verification
Every result appears one edge after the inputs that cause it. The requests and limit driven before edge k decide the grant that is readable right after edge k, and the wait counts and pointer also move at that edge. The bench therefore changes inputs on the falling edge and checks the grant on the next falling edge. For the starvation cases it steps through a known sequence from reset and counts the waited cycles edge by edge. Reset is checked while it is held and again after release, when the pointer must be back at 0.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int unsigned PROC_CNT = 20;
  localparam int unsigned BANK_CNT = 16;
  localparam int unsigned MASTER_CNT = PROC_CNT + BANK_CNT;
  localparam int unsigned IDX_W = $clog2(MASTER_CNT);
  localparam int unsigned WAIT_W = 8;
endpackage

// File: rtl/arb_wait_slot.sv
// Wait counter for one master; flags the master as starving once the limit is reached.
module arb_wait_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         won,
  input  logic [W-1:0] limit,
  output logic         starving
);
  logic [W-1:0] cnt_q;
  logic         at_cap;

  assign at_cap   = (cnt_q >= limit);
  assign starving = req && (limit != '0) && at_cap;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!req || won) cnt_q <= '0;
    else if (at_cap)     cnt_q <= limit;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R6: the count never climbs past the limit that was in force one edge earlier
  a_r6_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q <= $past(limit) || cnt_q == $past(cnt_q)));
endmodule

// File: rtl/arb_rr_pick.sv
// Picks the first set candidate at or above ptr, wrapping around to index 0.
module arb_rr_pick #(
  parameter int unsigned N  = 36,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  upper;
  logic          hit_hi;
  logic [IW-1:0] idx_hi;
  logic [IW-1:0] idx_lo;

  always_comb begin
    for (int i = 0; i < N; i++) upper[i] = cand[i] && (IW'(i) >= ptr);
    hit_hi = 1'b0;
    idx_hi = '0;
    idx_lo = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (upper[i]) begin
        hit_hi = 1'b1;
        idx_hi = IW'(i);
      end
      if (cand[i]) idx_lo = IW'(i);
    end
    hit = |cand;
    idx = hit_hi ? idx_hi : idx_lo;
  end

  // R4: the chosen index is always one of the candidates
  a_r4_pick_is_cand: assert final (!hit || cand[idx]);
endmodule

// File: rtl/bus_addr_arbiter.sv
module bus_addr_arbiter
  import bus_arb_pkg::*;
#(
  parameter int unsigned N_PROC = PROC_CNT,
  parameter int unsigned N_BANK = BANK_CNT,
  parameter int unsigned CNT_W  = WAIT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PROC-1:0]         req_proc,
  input  logic [N_BANK-1:0]         req_mem,
  input  logic [CNT_W-1:0]          wait_limit,
  output logic [N_PROC+N_BANK-1:0]  grant,
  output logic                      grant_valid
);
  localparam int unsigned N  = N_PROC + N_BANK;
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  req_all;
  logic [N-1:0]  starve_vec;
  logic [N-1:0]  cand;
  logic [N-1:0]  grant_next;
  logic [N-1:0]  grant_q;
  logic          lock_on;
  logic          hit;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] ptr_q;
  logic          valid_q;

  // R5: processors take the low indices, memory banks follow
  assign req_all = {req_mem, req_proc};

  for (genvar g = 0; g < N; g++) begin : g_slot
    arb_wait_slot #(.W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_all[g]),
      .won      (grant_next[g]),
      .limit    (wait_limit),
      .starving (starve_vec[g])
    );
  end

  // R7/R8: starving masters, when present, are the only candidates
  assign lock_on = |starve_vec;
  assign cand    = lock_on ? starve_vec : req_all;

  arb_rr_pick #(.N(N), .IW(IW)) u_pick (
    .cand (cand),
    .ptr  (ptr_q),
    .hit  (hit),
    .idx  (win_idx)
  );

  always_comb begin
    for (int i = 0; i < N; i++) grant_next[i] = hit && (win_idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      grant_q <= grant_next;
      valid_q <= hit;
      if (hit) ptr_q <= (win_idx == IW'(N - 1)) ? '0 : win_idx + 1'b1;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = valid_q;

  // R2: at most one grant bit, and the valid flag agrees with it
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_q));
  a_r2_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant_q != '0));
  // R3: a grant only goes to a master that requested at the edge before
  a_r3_granted_requested: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant_q & $past(req_all)) == grant_q));
  // R7: while a lock is active, the grant is confined to starving masters
  a_r7_lock_confines: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on |=> ((grant_q & $past(starve_vec)) == grant_q) && grant_valid);
  // R10: no request means no grant and no pointer movement
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_all == '0) |=> (!grant_valid && $stable(ptr_q)));
endmodule

// File: tb/bus_addr_arbiter_test.sv
`timescale 1ns/1ps
module bus_addr_arbiter_test;
  localparam int N = 36;
  localparam int ROWS = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [19:0]   req_proc = '0;
  logic [15:0]   req_mem = '0;
  logic [7:0]    wait_limit = '0;
  logic [N-1:0]  grant;
  logic          grant_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  bus_addr_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_proc(req_proc), .req_mem(req_mem),
    .wait_limit(wait_limit), .grant(grant), .grant_valid(grant_valid)
  );

  always #10 clk = ~clk;

  // row layout: limit[79:72], request mask[71:36], expected grant[35:0]
  localparam logic [79:0] VEC [ROWS] = '{
    {8'd0, 36'h000000021, 36'h000000001},  // R4 pointer 0 -> index 0
    {8'd0, 36'h000000021, 36'h000000020},  // R4 next after 0 -> 5
    {8'd0, 36'h000000021, 36'h000000001},  // R4 wrap back to 0
    {8'd0, 36'h800000000, 36'h800000000},  // R5 top bank index 35
    {8'd0, 36'h000000000, 36'h000000000},  // R10 idle
    {8'd0, 36'h800000001, 36'h000000001},  // R4 pointer wrapped to 0
    {8'd0, 36'h000100000, 36'h000100000},  // R5 bank 0 -> index 20
    {8'd0, 36'h000080008, 36'h000000008},  // R4 wrap from 21 -> 3
    {8'd2, 36'h040000020, 36'h000000020},  // R6 index 30 waits 1
    {8'd2, 36'h040000040, 36'h000000040},  // R6 index 30 waits 2
    {8'd2, 36'h040000080, 36'h040000000},  // R7 30 starving beats 7
    {8'd2, 36'h000000180, 36'h000000080},  // R4 from 31 wrap -> 7
    {8'd1, 36'h000000300, 36'h000000100},  // R7 8 starving
    {8'd1, 36'h000000012, 36'h000000002},  // R6 9 dropped, 1 wins
    {8'd1, 36'h000001018, 36'h000000010},  // R7 4 starving beats 3
    {8'd1, 36'h000001048, 36'h000001000},  // R8 starving 3,12 from ptr 5 -> 12
    {8'd1, 36'h000000048, 36'h000000008}   // R8 starving 3,6 from ptr 13 -> 3
  };

  task automatic drive(input logic [7:0] lim, input logic [N-1:0] mask);
    wait_limit = lim;
    req_proc   = mask[19:0];
    req_mem    = mask[35:20];
  endtask

  task automatic check(input string tag, input logic [N-1:0] exp);
    checks++;
    if (grant !== exp || grant_valid !== (exp != '0)) begin
      failures++;
      $display("FAIL %s: grant=%h valid=%b expected grant=%h valid=%b",
               tag, grant, grant_valid, exp, (exp != '0));
    end
  endtask

  task automatic step(input string tag, input logic [7:0] lim,
                      input logic [N-1:0] mask, input logic [N-1:0] exp);
    drive(lim, mask);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(8'd0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset holds the outputs at zero even with requests pending
    rst_n = 1'b0;
    drive(8'd0, 36'hFFFFFFFFF);
    repeat (2) @(negedge clk);
    check("R1 during reset", '0);
    drive(8'd0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0);

    // vector table walked as one continuous run
    for (int i = 0; i < ROWS; i++) begin
      step($sformatf("R2/R3 table row %0d", i), VEC[i][79:72], VEC[i][71:36], VEC[i][35:0]);
    end
    drive(8'd0, '0);
    @(posedge clk);
    @(negedge clk);
    check("R3 grant lasts one cycle", '0);

    // R9: limit 0, master 30 never takes over
    do_reset();
    step("R9 first", 8'd0, 36'h040000002, 36'h000000002);
    step("R9 second", 8'd0, 36'h040000004, 36'h000000004);
    step("R9 no lock", 8'd0, 36'h040000008, 36'h000000008);

    // R6: a dropped request clears the wait count
    do_reset();
    step("R6 start", 8'd2, 36'h040000002, 36'h000000002);
    step("R6 drop 30", 8'd2, 36'h000000004, 36'h000000004);
    step("R6 count restarted", 8'd2, 36'h040000008, 36'h000000008);

    // R1: reset in mid-run returns the pointer to index 0
    step("R1 pre", 8'd0, 36'h000000004, 36'h000000004);
    rst_n = 1'b0;
    drive(8'd0, 36'h000000021);
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run reset", '0);
    rst_n = 1'b1;
    step("R1 pointer at 0", 8'd0, 36'h000000021, 36'h000000001);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule